// File: doc/BRIEF.md
# Masked Register Write Commit Unit

This block retires the register side effects of one instruction bundle. A bundle produces a short queue of pending 32-bit writes. Each entry names a target register, gives a bit mask and gives a value. The unit applies these writes one entry per cycle, in queue order, to a small register file. The file holds general registers, a status word, a backup status register, a debug status register and a stack pointer.

When two entries in the queue both write the same condition flags of the status word, the earlier entry loses those flags. A caller flag can switch this arbitration off. After the queue drains, the unit applies a pending trap to the status word. If the commit touched the status word, it then brings the active stack-pointer bank into line with the stack-mode bit.

The caller presents the entry count, the flattened entry fields, the arbitration-disable flag and the trap code, and pulses `start_i` while the unit is idle. The unit latches everything on that edge and steps through five states. `ST_IDLE` waits for start. It moves to `ST_WRITE` when the count is nonzero and to `ST_TRAP` when the count is zero. `ST_WRITE` applies one entry per cycle and moves to `ST_TRAP` after the last entry. `ST_TRAP` applies the trap and always moves to `ST_SWAP`. `ST_SWAP` exchanges stack banks if needed and always moves to `ST_DONE`. `ST_DONE` raises the done pulse, clears the latched queue and trap code, and returns to `ST_IDLE`.

Top module: `commit_unit`

## Requirements
- R1: Entry k updates its target as new = (old & ~mask) | (value & mask). Target ids map as follows: 0 to NUM_GPR-1 are general registers, 40 is the status word, 41 is the backup status, 42 is the debug status and 43 is the live stack pointer. Entry k occupies bits [k*6 +: 6] of `id_i` and bits [k*32 +: 32] of `mask_i` and `val_i`.
- R2: Entries are applied in queue order, so a later entry's masked bits override an earlier entry's bits for the same target.
- R3: An entry whose id matches no target changes no register.
- R4: Status bit number n sits at vector position 31-n. The condition flags are n = 17, 18, 19, 20, 21, 22, 23 and 24, with V at n=22 and VA at n=23. When an earlier status entry shares any flag with the mask of a later status entry in the same queue, the earlier entry's mask loses the shared flags. Non-flag bits are never removed, and nothing is removed when no flag is shared.
- R5: When such a later status entry has V in its mask, the earlier entry also loses VA, even when VA is absent from the later mask.
- R6: With `lkr_i` high, no status mask is reduced and every entry is applied exactly as given.
- R7: Trap code 1 runs after the queue. It copies the status word into the backup status, then clears every status bit except DB (n=3) and SM (n=0).
- R8: Trap code 2 runs after the queue. It copies the status word into the debug status, then sets the status word to DS (n=4) alone. Codes 0 and 3 leave all status registers alone.
- R9: If the commit wrote the status word or took a trap, and SM differs from the active bank index, the live SP is saved into the old bank, the index takes the SM value, and SP is loaded from the new bank.
- R10: `done_o` is high for exactly one cycle, cnt+2 cycles after the edge that accepts `start_i`.
- R11: After reset every register, SP bank and the bank index read zero, and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a commit; sampled only in ST_IDLE |
| cnt_i | input | CW | Number of valid entries, saturated at DEPTH |
| id_i | input | DEPTH*IDW | Target id per entry |
| mask_i | input | DEPTH*32 | Write mask per entry |
| val_i | input | DEPTH*32 | Write value per entry |
| lkr_i | input | 1 | Disable flag arbitration on the status word |
| trap_i | input | 2 | Trap code: 0 none, 1 ordinary, 2 debug |
| busy_o | output | 1 | Commit in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 32 | Status word |
| bstat_o | output | 32 | Backup status register |
| dstat_o | output | 32 | Debug status register |
| sp_o | output | 32 | Live stack pointer |
| stack_sel_o | output | 1 | Active stack bank index |
| gpr_o | output | NUM_GPR*32 | General registers, register g at [g*32 +: 32] |

## Verification
The assertions assume that `start_i` is raised only while `busy_o` is low. They also assume that the entry fields stay stable from the accepting edge onward, and that `trap_i` carries one of the four codes. The bench drives every input on the falling edge and pulses start for a single cycle. It then holds all fields untouched until it has seen the done pulse and the cycle after it, so no commit ever overlaps another.

// File: rtl/commit_pkg.sv
package commit_pkg;
    localparam int DW = 32;

    localparam int ID_STATUS = 40;
    localparam int ID_BSTAT  = 41;
    localparam int ID_DSTAT  = 42;
    localparam int ID_SP     = 43;

    localparam int N_SM = 0;
    localparam int N_DB = 3;
    localparam int N_DS = 4;
    localparam int N_F0 = 17;
    localparam int N_F1 = 18;
    localparam int N_F2 = 19;
    localparam int N_F3 = 20;
    localparam int N_S  = 21;
    localparam int N_V  = 22;
    localparam int N_VA = 23;
    localparam int N_C  = 24;

    localparam int P_SM = DW - 1 - N_SM;
    localparam int P_V  = DW - 1 - N_V;
    localparam int P_VA = DW - 1 - N_VA;

    localparam logic [DW-1:0] M_SM = DW'(1) << (DW - 1 - N_SM);
    localparam logic [DW-1:0] M_DB = DW'(1) << (DW - 1 - N_DB);
    localparam logic [DW-1:0] M_DS = DW'(1) << (DW - 1 - N_DS);
    localparam logic [DW-1:0] FLAG_MASK =
        (DW'(1) << (DW - 1 - N_F0)) | (DW'(1) << (DW - 1 - N_F1)) |
        (DW'(1) << (DW - 1 - N_F2)) | (DW'(1) << (DW - 1 - N_F3)) |
        (DW'(1) << (DW - 1 - N_S))  | (DW'(1) << (DW - 1 - N_V))  |
        (DW'(1) << (DW - 1 - N_VA)) | (DW'(1) << (DW - 1 - N_C));

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_TRAP,
        ST_SWAP,
        ST_DONE
    } commit_state_e;

    typedef enum logic [1:0] {
        TRAP_NONE = 2'd0,
        TRAP_ORD  = 2'd1,
        TRAP_DBG  = 2'd2,
        TRAP_RSV  = 2'd3
    } trap_e;

    function automatic logic [DW-1:0] merge_bits(input logic [DW-1:0] old_v,
                                                 input logic [DW-1:0] msk,
                                                 input logic [DW-1:0] nv);
        return (old_v & ~msk) | (nv & msk);
    endfunction
endpackage

// File: rtl/commit_flag_resolver.sv
module commit_flag_resolver
    import commit_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IDW   = 6,
    parameter int CW    = 3,
    parameter int IW    = 2
) (
    input  logic [IW-1:0]        cur_i,
    input  logic [CW-1:0]        cnt_i,
    input  logic [DEPTH*IDW-1:0] id_i,
    input  logic [DEPTH*DW-1:0]  mask_i,
    input  logic                 lkr_i,
    output logic [DW-1:0]        mask_o
);
    logic [DW-1:0] eff;
    logic [DW-1:0] mine;
    logic [DW-1:0] later;

    always_comb begin
        eff   = mask_i[int'(cur_i)*DW +: DW];
        mine  = eff & FLAG_MASK;
        later = '0;
        if (!lkr_i && id_i[int'(cur_i)*IDW +: IDW] == IDW'(ID_STATUS)) begin
            for (int j = 0; j < DEPTH; j++) begin
                later = mask_i[j*DW +: DW];
                if (j > int'(cur_i) && j < int'(cnt_i) &&
                    id_i[j*IDW +: IDW] == IDW'(ID_STATUS) &&
                    (later & mine) != '0) begin
                    eff = eff & ~(later & mine);
                    if (later[P_V]) begin
                        eff[P_VA] = 1'b0;
                    end
                end
            end
        end
        mask_o = eff;
    end
endmodule

// File: rtl/commit_trap_unit.sv
module commit_trap_unit
    import commit_pkg::*;
(
    input  logic [1:0]    code_i,
    input  logic [DW-1:0] status_i,
    output logic [DW-1:0] status_o,
    output logic          save_b_o,
    output logic          save_d_o
);
    always_comb begin
        status_o = status_i;
        save_b_o = 1'b0;
        save_d_o = 1'b0;
        unique case (trap_e'(code_i))
            TRAP_ORD: begin
                status_o = status_i & (M_DB | M_SM);
                save_b_o = 1'b1;
            end
            TRAP_DBG: begin
                status_o = M_DS;
                save_d_o = 1'b1;
            end
            TRAP_NONE, TRAP_RSV: begin
                status_o = status_i;
            end
        endcase
    end
endmodule

// File: rtl/commit_sp_bank.sv
module commit_sp_bank
    import commit_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_mask_i,
    input  logic [DW-1:0] wr_val_i,
    input  logic          swap_en_i,
    input  logic          new_sel_i,
    output logic [DW-1:0] sp_o,
    output logic          sel_o
);
    logic [DW-1:0] bank_q [2];
    logic [DW-1:0] sp_q;
    logic          sel_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bank_q[0] <= '0;
            bank_q[1] <= '0;
            sp_q      <= '0;
            sel_q     <= 1'b0;
        end else if (swap_en_i) begin
            bank_q[sel_q] <= sp_q;
            sel_q         <= new_sel_i;
            sp_q          <= bank_q[new_sel_i];
        end else if (wr_en_i) begin
            sp_q <= merge_bits(sp_q, wr_mask_i, wr_val_i);
        end
    end

    assign sp_o  = sp_q;
    assign sel_o = sel_q;
endmodule

// File: rtl/commit_unit.sv
module commit_unit
    import commit_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int NUM_GPR = 8,
    parameter int IDW     = 6,
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int IW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    start_i,
    input  logic [CW-1:0]           cnt_i,
    input  logic [DEPTH*IDW-1:0]    id_i,
    input  logic [DEPTH*32-1:0]     mask_i,
    input  logic [DEPTH*32-1:0]     val_i,
    input  logic                    lkr_i,
    input  logic [1:0]              trap_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [31:0]             status_o,
    output logic [31:0]             bstat_o,
    output logic [31:0]             dstat_o,
    output logic [31:0]             sp_o,
    output logic                    stack_sel_o,
    output logic [NUM_GPR*32-1:0]   gpr_o
);
    commit_state_e state_q, state_d;

    logic [DEPTH*IDW-1:0] q_id;
    logic [DEPTH*DW-1:0]  q_mask;
    logic [DEPTH*DW-1:0]  q_val;
    logic [CW-1:0]        q_cnt;
    logic                 q_lkr;
    logic [1:0]           q_trap;
    logic [IW-1:0]        idx_q;
    logic                 touched_q;

    logic [DW-1:0] gpr_q [NUM_GPR];
    logic [DW-1:0] status_q, bstat_q, dstat_q;

    logic [CW-1:0]  cnt_clamp;
    logic [IDW-1:0] cur_id;
    logic [DW-1:0]  cur_raw_mask, cur_val, eff_mask;
    logic           last_entry;
    logic [DW-1:0]  trap_status;
    logic           save_b, save_d;
    logic           sp_wr_en, swap_en;
    logic [DW-1:0]  sp_w;
    logic           sp_sel;

    assign cnt_clamp    = (int'(cnt_i) > DEPTH) ? CW'(DEPTH) : cnt_i;
    assign cur_id       = q_id[int'(idx_q)*IDW +: IDW];
    assign cur_raw_mask = q_mask[int'(idx_q)*DW +: DW];
    assign cur_val      = q_val[int'(idx_q)*DW +: DW];
    assign last_entry   = (int'(idx_q) + 1 >= int'(q_cnt));

    commit_flag_resolver #(
        .DEPTH(DEPTH), .IDW(IDW), .CW(CW), .IW(IW)
    ) resolver_i (
        .cur_i  (idx_q),
        .cnt_i  (q_cnt),
        .id_i   (q_id),
        .mask_i (q_mask),
        .lkr_i  (q_lkr),
        .mask_o (eff_mask)
    );

    commit_trap_unit trap_i_u (
        .code_i   (q_trap),
        .status_i (status_q),
        .status_o (trap_status),
        .save_b_o (save_b),
        .save_d_o (save_d)
    );

    assign sp_wr_en = (state_q == ST_WRITE) && (cur_id == IDW'(ID_SP));
    assign swap_en  = (state_q == ST_SWAP) && touched_q && (status_q[P_SM] != sp_sel);

    commit_sp_bank sp_bank_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (sp_wr_en),
        .wr_mask_i (eff_mask),
        .wr_val_i  (cur_val),
        .swap_en_i (swap_en),
        .new_sel_i (status_q[P_SM]),
        .sp_o      (sp_w),
        .sel_o     (sp_sel)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = (cnt_clamp == '0) ? ST_TRAP : ST_WRITE;
            ST_WRITE: if (last_entry) state_d = ST_TRAP;
            ST_TRAP:  state_d = ST_SWAP;
            ST_SWAP:  state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Register file and queue copy
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q_id      <= '0;
            q_mask    <= '0;
            q_val     <= '0;
            q_cnt     <= '0;
            q_lkr     <= 1'b0;
            q_trap    <= '0;
            idx_q     <= '0;
            touched_q <= 1'b0;
            status_q  <= '0;
            bstat_q   <= '0;
            dstat_q   <= '0;
            for (int g = 0; g < NUM_GPR; g++) gpr_q[g] <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        q_id      <= id_i;
                        q_mask    <= mask_i;
                        q_val     <= val_i;
                        q_cnt     <= cnt_clamp;
                        q_lkr     <= lkr_i;
                        q_trap    <= trap_i;
                        idx_q     <= '0;
                        touched_q <= 1'b0;
                    end
                end
                ST_WRITE: begin
                    for (int g = 0; g < NUM_GPR; g++) begin
                        if (int'(cur_id) == g) gpr_q[g] <= merge_bits(gpr_q[g], eff_mask, cur_val);
                    end
                    if (cur_id == IDW'(ID_STATUS)) begin
                        status_q  <= merge_bits(status_q, eff_mask, cur_val);
                        touched_q <= 1'b1;
                    end
                    if (cur_id == IDW'(ID_BSTAT)) bstat_q <= merge_bits(bstat_q, eff_mask, cur_val);
                    if (cur_id == IDW'(ID_DSTAT)) dstat_q <= merge_bits(dstat_q, eff_mask, cur_val);
                    idx_q <= idx_q + 1'b1;
                end
                ST_TRAP: begin
                    if (save_b) bstat_q <= status_q;
                    if (save_d) dstat_q <= status_q;
                    status_q <= trap_status;
                    if (save_b || save_d) touched_q <= 1'b1;
                end
                ST_SWAP: begin
                    idx_q <= '0;
                end
                ST_DONE: begin
                    q_id   <= '0;
                    q_mask <= '0;
                    q_val  <= '0;
                    q_cnt  <= '0;
                    q_trap <= '0;
                end
                default: ;
            endcase
        end
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = (state_q == ST_DONE);
    assign status_o    = status_q;
    assign bstat_o     = bstat_q;
    assign dstat_o     = dstat_q;
    assign sp_o        = sp_w;
    assign stack_sel_o = sp_sel;

    for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr_out
        assign gpr_o[g*32 +: 32] = gpr_q[g];
    end

    assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_mask_shrinks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_WRITE) |-> ((eff_mask & ~cur_raw_mask) == '0));

    assert_lkr_passthrough_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_WRITE && q_lkr) |-> (eff_mask == cur_raw_mask));

    assert_ord_trap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_TRAP && q_trap == 2'd1) |=>
            (((status_q & ~(M_DB | M_SM)) == '0) && (bstat_q == $past(status_q))));

    assert_dbg_trap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_TRAP && q_trap == 2'd2) |=>
            ((status_q == M_DS) && (dstat_q == $past(status_q))));

    assert_bank_follows_sm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_DONE && touched_q) |-> (sp_sel == status_q[P_SM]));
endmodule

// File: tb/commit_unit_tb.sv
`timescale 1ns/1ps
module commit_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   cnt = '0;
    logic [23:0]  ids = '0;
    logic [127:0] masks = '0;
    logic [127:0] vals = '0;
    logic         lkr = 1'b0;
    logic [1:0]   trap = '0;
    logic         busy, done;
    logic [31:0]  status, bstat, dstat, sp;
    logic         sel;
    logic [255:0] gpr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    commit_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cnt_i(cnt),
        .id_i(ids), .mask_i(masks), .val_i(vals), .lkr_i(lkr), .trap_i(trap),
        .busy_o(busy), .done_o(done), .status_o(status), .bstat_o(bstat),
        .dstat_o(dstat), .sp_o(sp), .stack_sel_o(sel), .gpr_o(gpr)
    );

    localparam int NV = 7;
    localparam logic [2:0] V_CNT [NV] = '{3'd3, 3'd2, 3'd2, 3'd2, 3'd1, 3'd1, 3'd1};
    localparam logic [23:0] V_ID [NV] = '{
        24'h0,
        {6'd0, 6'd0, 6'd40, 6'd40},
        {6'd0, 6'd0, 6'd40, 6'd40},
        {6'd0, 6'd0, 6'd40, 6'd40},
        {6'd0, 6'd0, 6'd40, 6'd40},
        {6'd0, 6'd0, 6'd40, 6'd40},
        {6'd0, 6'd0, 6'd0, 6'd20}};
    localparam logic [127:0] V_MASK [NV] = '{
        {32'h0, 32'h0000_00FF, 32'hFF00_0000, 32'h0000_FFFF},
        {32'h0, 32'h0, 32'h0000_0200, 32'h0100_0300},
        {32'h0, 32'h0, 32'h0000_0200, 32'h0000_0300},
        {32'h0, 32'h0, 32'h0000_0200, 32'h0000_0100},
        {32'h0, 32'h0, 32'h0, 32'h1000_0000},
        {32'h0, 32'h0, 32'h0, 32'h00FF_0000},
        {32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF}};
    localparam logic [127:0] V_VAL [NV] = '{
        {32'h0, 32'h0000_00CD, 32'hAB00_0000, 32'h1234_5678},
        {32'h0, 32'h0, 32'h0000_0200, 32'h0100_0300},
        {32'h0, 32'h0, 32'h0000_0200, 32'h0000_0300},
        {32'h0, 32'h0, 32'h0, 32'h0},
        {32'h0, 32'h0, 32'h0, 32'h1000_0000},
        {32'h0, 32'h0, 32'h0, 32'h0012_0000},
        {32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF}};
    localparam logic V_LKR [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam logic [1:0] V_TRAP [NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd0};
    localparam logic [31:0] V_STAT [NV] = '{32'h0, 32'h0100_0200, 32'h0100_0300,
        32'h0100_0000, 32'h1000_0000, 32'h0800_0000, 32'h0800_0000};
    localparam logic [31:0] V_BST [NV] = '{32'h0, 32'h0, 32'h0, 32'h0,
        32'h1100_0000, 32'h1100_0000, 32'h1100_0000};
    localparam logic [31:0] V_DST [NV] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
        32'h1012_0000, 32'h1012_0000};
    localparam string V_REQ [NV] = '{"R1 R2", "R4 R5", "R6", "R4", "R7", "R8", "R3"};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_commit(input logic [2:0] c, input logic [23:0] i, input logic [127:0] m,
                              input logic [127:0] v, input logic l, input logic [1:0] t,
                              output int lat, output logic done_after);
        @(negedge clk);
        cnt = c; ids = i; masks = m; vals = v; lkr = l; trap = t;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 64) begin
            @(negedge clk);
            lat++;
        end
        if (lat >= 64) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual no done expected done");
        end
        @(negedge clk);
        done_after = done;
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        logic da;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 status", status, 32'h0);
        chk("R11 sp", sp, 32'h0);
        chk("R11 sel", {31'h0, sel}, 32'h0);
        chk("R11 done", {31'h0, done}, 32'h0);
        chk("R11 gpr0", gpr[31:0], 32'h0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            run_commit(V_CNT[k], V_ID[k], V_MASK[k], V_VAL[k], V_LKR[k], V_TRAP[k], lat, da);
            chk({V_REQ[k], " status"}, status, V_STAT[k]);
            chk({V_REQ[k], " bstat"}, bstat, V_BST[k]);
            chk({V_REQ[k], " dstat"}, dstat, V_DST[k]);
            chk({V_REQ[k], " gpr0"}, gpr[31:0], (k == 0 || k > 0) ? 32'hAB00_56CD : 32'h0);
            chk("R10 latency", lat, 32'(V_CNT[k]) + 32'd2);
            chk("R10 pulse width", {31'h0, da}, 32'h0);
        end

        // R1: direct SP write
        run_commit(3'd1, {18'h0, 6'd43}, {96'h0, 32'hFFFF_FFFF}, {96'h0, 32'h1111_1111}, 1'b0, 2'd0, lat, da);
        chk("R1 sp write", sp, 32'h1111_1111);
        // R9: set SM, swap to bank 1
        run_commit(3'd1, {18'h0, 6'd40}, {96'h0, 32'h8000_0000}, {96'h0, 32'h8000_0000}, 1'b0, 2'd0, lat, da);
        chk("R9 sel after SM set", {31'h0, sel}, 32'h1);
        chk("R9 sp from bank1", sp, 32'h0);
        run_commit(3'd1, {18'h0, 6'd43}, {96'h0, 32'hFFFF_FFFF}, {96'h0, 32'h2222_2222}, 1'b0, 2'd0, lat, da);
        // R9: clear SM, swap back
        run_commit(3'd1, {18'h0, 6'd40}, {96'h0, 32'h8000_0000}, {96'h0, 32'h0}, 1'b0, 2'd0, lat, da);
        chk("R9 sel after SM clear", {31'h0, sel}, 32'h0);
        chk("R9 sp from bank0", sp, 32'h1111_1111);
        // R7 with R9: ordinary trap keeps SM
        run_commit(3'd1, {18'h0, 6'd40}, {96'h0, 32'h8000_0000}, {96'h0, 32'h8000_0000}, 1'b0, 2'd1, lat, da);
        chk("R7 status keeps SM", status, 32'h8000_0000);
        chk("R7 bstat", bstat, 32'h8800_0000);
        chk("R9 sp after trap", sp, 32'h2222_2222);
        // R8 with R9: debug trap clears SM
        run_commit(3'd0, 24'h0, 128'h0, 128'h0, 1'b0, 2'd2, lat, da);
        chk("R8 status", status, 32'h0800_0000);
        chk("R8 dstat", dstat, 32'h8000_0000);
        chk("R9 sel after debug trap", {31'h0, sel}, 32'h0);
        chk("R9 sp after debug trap", sp, 32'h1111_1111);
        // R10: empty commit
        run_commit(3'd0, 24'h0, 128'h0, 128'h0, 1'b0, 2'd0, lat, da);
        chk("R10 empty latency", lat, 32'd2);
        chk("R8 code0 status unchanged", status, 32'h0800_0000);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule